// File: doc/BRIEF.md
# Processor Status Register with Flag-Write Arbitration

This block is the single 8-bit status register of a small processor core. It stores three arithmetic flags (zero, half carry, carry), two wake-cause bits that record whether the last restart followed a watchdog expiry or a sleep, and three bank-select bits that steer data-memory addressing. The register file presents this one copy at the same offset in every data-memory bank, because the bank bits must stay reachable whatever bank is active. The block drives the bank-select bits straight to the address logic.

Each cycle the block decides, bit by bit, where the next value comes from: a register-file write, the flag results of the instruction now executing, or a power-management event. Flag results win over a data write on the three flag bits. When an instruction that updates any flag writes its result here, none of the three flag bits takes the written data. The wake-cause bits can only be changed by events, never by a write. During subtraction the carry and half-carry inputs already arrive in inverted borrow sense from the ALU (1 = no borrow), and the block stores them unchanged.

A parameter selects whether the upper bank-select bits exist. When they do not, those bits are still stored but are held at zero.

Top module: `cpu_stat_reg`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the register to 8'h18: bits 7:5 = 0, bit 4 (no-timeout) = 1, bit 3 (no-sleep) = 1, bits 2:0 (zero at bit 2, half carry at bit 1, carry at bit 0) = 0.
- R2: A write (wr_en = 1) with all of flag_upd = 0 loads wr_data bits 7:5 and 2:0 into the register at the next edge.
- R3: A write while any flag_upd bit is 1 leaves every one of bits 2:0 unaffected by wr_data. Each flag whose enable is set (flag_upd[2] = zero, [1] = half carry, [0] = carry) takes the matching flag_val bit, and the others hold.
- R4: Without a write, a flag enable loads only its own flag from flag_val, and all other bits hold.
- R5: Bits 4:3 never take wr_data. They change only through the events in R6 to R8.
- R6: wdt_expire clears bit 4 and leaves bit 3 unchanged.
- R7: sleep_exec (without wdt_expire) clears bit 3 and sets bit 4.
- R8: wdt_clear (without the other two events) sets bits 4 and 3. The event priority is wdt_expire over sleep_exec over wdt_clear.
- R9: A clear-register operation (write of 8'h00 with only the zero enable set and flag_val zero = 1) gives 000u u1uu: bits 7:5 cleared, bit 2 set, bits 4:3 and 1:0 unchanged.
- R10: dir_bank equals register bits 6:5 and ind_bank equals bit 7. A value written in a cycle is not seen on stat_q, dir_bank or ind_bank until after the next rising edge.
- R11: With HAS_UPPER_BANK = 0, bits 7:6 stay 0 whatever is written. Bit 5 still behaves as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register-file write to the status register |
| wr_data | input | 8 | Data for the write |
| flag_upd | input | 3 | Per-flag update enables {zero, half carry, carry} |
| flag_val | input | 3 | Flag results from the ALU {zero, half carry, carry} |
| wdt_expire | input | 1 | Watchdog timer expired |
| sleep_exec | input | 1 | Sleep instruction executed |
| wdt_clear | input | 1 | Watchdog cleared by instruction |
| stat_q | output | 8 | Current register value |
| dir_bank | output | 2 | Direct-addressing bank select |
| ind_bank | output | 1 | Indirect-addressing bank select |

## Verification
The properties take all inputs as known (not X) at every rising edge once reset is released. They accept any mix of write, flag enables and events in one cycle, because the block has to resolve those mixes itself. The stimulus is driven only from tasks that move the inputs a fixed delay after the rising edge, so every value is settled long before the next edge. It combines writes with partial flag enables and with stacked events, and these are the cases the arbitration properties cover.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int STAT_W  = 8;
    localparam int NFLAG   = 3;
    localparam int NBANK   = 3;
    localparam int NWAKE   = 2;

    // bit positions that neighbouring logic decodes
    localparam int B_IBANK = 7;
    localparam int B_DHI   = 6;
    localparam int B_DLO   = 5;
    localparam int B_NOTMO = 4;
    localparam int B_NOSLP = 3;
    localparam int B_ZERO  = 2;
    localparam int B_HALF  = 1;
    localparam int B_CARRY = 0;

    typedef struct packed {
        logic ibank;
        logic dbank_hi;
        logic dbank_lo;
        logic no_tmo;
        logic no_slp;
        logic zero;
        logic half_c;
        logic carry;
    } stat_t;

    typedef struct packed {
        logic no_tmo;
        logic no_slp;
    } wake_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_TMO   = 2'd1,
        EV_SLEEP = 2'd2,
        EV_CLEAR = 2'd3
    } wake_ev_e;

    function automatic stat_t stat_reset_val();
        stat_t v;
        v        = '0;
        v.no_tmo = 1'b1;
        v.no_slp = 1'b1;
        return v;
    endfunction

    function automatic wake_ev_e pick_event(input logic tmo, input logic slp,
                                            input logic clr);
        if (tmo)      return EV_TMO;
        else if (slp) return EV_SLEEP;
        else if (clr) return EV_CLEAR;
        else          return EV_NONE;
    endfunction

endpackage

// File: rtl/stat_flag_arb.sv
module stat_flag_arb
    import stat_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic [N-1:0] cur,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] alu,
    output logic [N-1:0] nxt
);
    logic any_upd;
    logic data_ok;

    always_comb begin
        any_upd = |upd;
        data_ok = wr_en && !any_upd;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            if (upd[i])
                nxt[i] = alu[i];
            else if (data_ok)
                nxt[i] = wr_bits[i];
            else
                nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/stat_wake_cause.sv
module stat_wake_cause
    import stat_pkg::*;
(
    input  wake_t cur,
    input  logic  tmo,
    input  logic  slp,
    input  logic  clr,
    output wake_t nxt
);
    wake_ev_e ev;

    always_comb begin
        ev  = pick_event(tmo, slp, clr);
        nxt = cur;
        unique case (ev)
            EV_TMO:   nxt.no_tmo = 1'b0;
            EV_SLEEP: begin
                nxt.no_tmo = 1'b1;
                nxt.no_slp = 1'b0;
            end
            EV_CLEAR: begin
                nxt.no_tmo = 1'b1;
                nxt.no_slp = 1'b1;
            end
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/stat_bank_sel.sv
module stat_bank_sel
    import stat_pkg::*;
#(
    parameter bit HAS_UPPER = 1'b1
) (
    input  logic [NBANK-1:0] cur,
    input  logic             wr_en,
    input  logic [NBANK-1:0] wr_bits,
    output logic [NBANK-1:0] nxt
);
    localparam int UPPER_N = NBANK - 1;

    always_comb begin
        nxt[0] = wr_en ? wr_bits[0] : cur[0];
    end

    if (HAS_UPPER) begin : g_full
        always_comb begin
            nxt[NBANK-1:1] = wr_en ? wr_bits[NBANK-1:1] : cur[NBANK-1:1];
        end
    end else begin : g_lean
        always_comb begin
            nxt[NBANK-1:1] = {UPPER_N{1'b0}};
        end
    end
endmodule

// File: rtl/cpu_stat_reg.sv
module cpu_stat_reg
    import stat_pkg::*;
#(
    parameter bit HAS_UPPER_BANK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [NFLAG-1:0]  flag_upd,
    input  logic [NFLAG-1:0]  flag_val,
    input  logic              wdt_expire,
    input  logic              sleep_exec,
    input  logic              wdt_clear,
    output logic [STAT_W-1:0] stat_q,
    output logic [1:0]        dir_bank,
    output logic              ind_bank
);
    stat_t            cur_r;
    stat_t            nxt;
    logic [NFLAG-1:0] flag_nxt;
    logic [NBANK-1:0] bank_nxt;
    wake_t            wake_cur;
    wake_t            wake_nxt;

    always_comb begin
        wake_cur.no_tmo = cur_r.no_tmo;
        wake_cur.no_slp = cur_r.no_slp;
    end

    stat_flag_arb #(.N(NFLAG)) u_flags (
        .cur     ({cur_r.zero, cur_r.half_c, cur_r.carry}),
        .wr_en   (wr_en),
        .wr_bits (wr_data[B_ZERO:B_CARRY]),
        .upd     (flag_upd),
        .alu     (flag_val),
        .nxt     (flag_nxt)
    );

    stat_wake_cause u_wake (
        .cur (wake_cur),
        .tmo (wdt_expire),
        .slp (sleep_exec),
        .clr (wdt_clear),
        .nxt (wake_nxt)
    );

    stat_bank_sel #(.HAS_UPPER(HAS_UPPER_BANK)) u_bank (
        .cur     ({cur_r.ibank, cur_r.dbank_hi, cur_r.dbank_lo}),
        .wr_en   (wr_en),
        .wr_bits (wr_data[B_IBANK:B_DLO]),
        .nxt     (bank_nxt)
    );

    always_comb begin
        nxt.ibank    = bank_nxt[2];
        nxt.dbank_hi = bank_nxt[1];
        nxt.dbank_lo = bank_nxt[0];
        nxt.no_tmo   = wake_nxt.no_tmo;
        nxt.no_slp   = wake_nxt.no_slp;
        nxt.zero     = flag_nxt[2];
        nxt.half_c   = flag_nxt[1];
        nxt.carry    = flag_nxt[0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_r <= stat_reset_val();
        else
            cur_r <= nxt;
    end

    always_comb begin
        stat_q   = cur_r;
        dir_bank = {cur_r.dbank_hi, cur_r.dbank_lo};
        ind_bank = cur_r.ibank;
    end
endmodule

// File: rtl/cpu_stat_reg_chk.sv
module cpu_stat_reg_chk
    import stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [NFLAG-1:0]  flag_upd,
    input logic [NFLAG-1:0]  flag_val,
    input logic              wdt_expire,
    input logic              sleep_exec,
    input logic              wdt_clear,
    input logic [STAT_W-1:0] stat_q,
    input logic [1:0]        dir_bank,
    input logic              ind_bank
);
    logic no_ev;
    assign no_ev = !wdt_expire && !sleep_exec && !wdt_clear;

    assert_reset_val_R1: assert property (@(posedge clk)
        rst |=> stat_q == 8'h18);

    assert_flag_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flag_upd[0]) |=> stat_q[B_CARRY] == $past(flag_val[0]));

    assert_write_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flag_upd == 3'b100) |=> stat_q[1:0] == $past(stat_q[1:0]));

    assert_zero_update_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && flag_upd[2]) |=> stat_q[B_ZERO] == $past(flag_val[2]));

    assert_wake_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        no_ev |=> $stable(stat_q[4:3]));

    assert_tmo_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> !stat_q[B_NOTMO] && $stable(stat_q[B_NOSLP]));

    assert_sleep_R7: assert property (@(posedge clk) disable iff (rst)
        (sleep_exec && !wdt_expire) |=> stat_q[4:3] == 2'b10);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wdt_clear && !sleep_exec && !wdt_expire) |=> stat_q[4:3] == 2'b11);

    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(dir_bank) && $stable(ind_bank));

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> stat_q[B_DLO] == $past(wr_data[B_DLO]));
endmodule

bind cpu_stat_reg cpu_stat_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flag_upd   (flag_upd),
    .flag_val   (flag_val),
    .wdt_expire (wdt_expire),
    .sleep_exec (sleep_exec),
    .wdt_clear  (wdt_clear),
    .stat_q     (stat_q),
    .dir_bank   (dir_bank),
    .ind_bank   (ind_bank)
);

// File: tb/sim_cpu_stat_reg.sv
module sim_cpu_stat_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] flag_upd = 3'b000;
    logic [2:0] flag_val = 3'b000;
    logic       wdt_expire = 1'b0;
    logic       sleep_exec = 1'b0;
    logic       wdt_clear = 1'b0;
    logic [7:0] stat_q, stat_q1;
    logic [1:0] dir_bank, dir_bank1;
    logic       ind_bank, ind_bank1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_stat_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .flag_upd(flag_upd), .flag_val(flag_val), .wdt_expire(wdt_expire),
        .sleep_exec(sleep_exec), .wdt_clear(wdt_clear),
        .stat_q(stat_q), .dir_bank(dir_bank), .ind_bank(ind_bank)
    );

    cpu_stat_reg #(.HAS_UPPER_BANK(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .flag_upd(flag_upd), .flag_val(flag_val), .wdt_expire(wdt_expire),
        .sleep_exec(sleep_exec), .wdt_clear(wdt_clear),
        .stat_q(stat_q1), .dir_bank(dir_bank1), .ind_bank(ind_bank1)
    );

    // {wr_en, wr_data, flag_upd, flag_val, {tmo,slp,clr}, expected}
    localparam int NVEC = 14;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 8'hE3, 3'b000, 3'b000, 3'b000, 8'hFB},  // R2 R5
        {1'b1, 8'h00, 3'b100, 3'b100, 3'b000, 8'h1F},  // R9
        {1'b0, 8'hFF, 3'b001, 3'b000, 3'b000, 8'h1E},  // R4
        {1'b1, 8'hFF, 3'b010, 3'b000, 3'b000, 8'hFC},  // R3
        {1'b0, 8'h00, 3'b000, 3'b000, 3'b100, 8'hEC},  // R6
        {1'b1, 8'hFF, 3'b000, 3'b000, 3'b000, 8'hEF},  // R5
        {1'b0, 8'h00, 3'b000, 3'b000, 3'b001, 8'hFF},  // R8
        {1'b0, 8'h00, 3'b000, 3'b000, 3'b010, 8'hF7},  // R7
        {1'b0, 8'h00, 3'b000, 3'b000, 3'b111, 8'hE7},  // R8 priority
        {1'b0, 8'h00, 3'b000, 3'b000, 3'b011, 8'hF7},  // R8 priority
        {1'b1, 8'h00, 3'b000, 3'b000, 3'b100, 8'h00},  // R5 R6
        {1'b0, 8'hFF, 3'b111, 3'b101, 3'b000, 8'h05},  // R4
        {1'b1, 8'hA0, 3'b000, 3'b000, 3'b000, 8'hA0},  // R2 R10
        {1'b1, 8'h5A, 3'b011, 3'b010, 3'b000, 8'h42}   // R3
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [25:0] v);
        wr_en      = v[25];
        wr_data    = v[24:17];
        flag_upd   = v[16:14];
        flag_val   = v[13:11];
        wdt_expire = v[10];
        sleep_exec = v[9];
        wdt_clear  = v[8];
    endtask

    task automatic idle();
        drive(26'd0);
    endtask

    initial begin
        // reset held over two edges
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 reset value", stat_q, 8'h18);
        check("R11 reset value lean", stat_q1, 8'h18);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            @(posedge clk);
            #2;
            check("R2-table vector", stat_q, VEC[i][7:0]);
            check("R10 bank outputs", {5'd0, ind_bank, dir_bank},
                  {5'd0, VEC[i][7:5]});
            check("R11 lean instance", stat_q1, VEC[i][7:0] & 8'h3F);
        end

        // R10: same-cycle read shows old value
        drive({1'b1, 8'h60, 3'b000, 3'b000, 3'b000, 8'h00});
        #1;
        check("R10 old value before edge", stat_q, 8'h42);
        @(posedge clk);
        #2;
        idle();
        check("R10 new value after edge", {6'd0, dir_bank}, 8'h03);
        check("R11 upper bits held clear", {6'd0, dir_bank1}, 8'h01);

        // R1: reset mid-run overrides a write
        rst = 1'b1;
        drive({1'b1, 8'hFF, 3'b111, 3'b111, 3'b010, 8'h00});
        @(posedge clk);
        #2;
        rst = 1'b0;
        idle();
        check("R1 reset overrides write", stat_q, 8'h18);

        // R9 from reset: clear op sets zero only
        drive({1'b1, 8'h00, 3'b100, 3'b100, 3'b000, 8'h00});
        @(posedge clk);
        #2;
        idle();
        check("R9 clear op from reset", stat_q, 8'h1C);

        // R4: idle cycle holds everything
        @(posedge clk);
        #2;
        check("R4 idle hold", stat_q, 8'h1C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule